// File: doc/BRIEF.md
# EDO DRAM Cycle-Mode Decoder

This block sits on the memory side of an asynchronous EDO DRAM interface. It samples the row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe on a fast system clock. From the order of their edges it works out which kind of cycle the controller is running. It can serve as a protocol checker or as the front end of a behavioural memory model. The storage array and the analog timing margins are not part of it.

The cycle class comes from the row strobe's falling edge and from the logical OR of the two column strobes. The class starts at the first column strobe that falls and holds until both have risen again. Each byte lane keeps its own write enable and its own output-drive decision, and these depend only on that lane's column strobe. All strobes are active low. Every output is registered, so it shows the effect of the strobe values sampled at a rising clock edge from that same edge on.

Top module: `edo_mode_decoder`

## Requirements
- R1: While the row strobe is high, `mode` reads 0 (standby). The codes are 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh.
- R2: If either column strobe is low when the row strobe falls, `mode` becomes 6. It stays 6 for the rest of that row cycle, whatever the column and write strobes do, and no lane write is raised.
- R3: If both column strobes are high when the row strobe falls, `mode` becomes 5 and holds there until a column strobe falls.
- R4: With the row strobe low, the first column strobe falling from the all-high state sets `mode` to 1 if the write strobe is high and to 2 if it is low. In page operation every new column cycle is classified again in the same way.
- R5: During a read, a falling write strobe while a column strobe is low sets `mode` to 4 if output enable was seen low since the column strobe fell, and to 3 otherwise.
- R6: `wr_en[i]` (bit 0 lower lane, bit 1 upper lane) is high exactly when the row strobe is low, lane i's column strobe is low, the write strobe is low and the mode is 2, 3 or 4.
- R7: A lane starts driving (`drv_en[i]`) only in a read, with its column strobe low, output enable low and the write strobe high. Early writes never drive, and a low write strobe stops the drive.
- R8: Once driving, a lane keeps driving until both the row strobe and its own column strobe are high. This holds through page gaps and through a hidden refresh, provided output enable stays low and the write strobe stays high.
- R9: A lane whose column strobe stays high gets neither a write enable nor output drive.
- R10: `proto_err` rises when, within one column cycle, one lane's column strobe falls with the write strobe low and the other's falls with it high. It stays high until the row strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe per byte lane, bit 0 lower, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| mode | output | 3 | Cycle class code |
| wr_en | output | LANES | Per-lane write enable |
| drv_en | output | LANES | Per-lane data output drive |
| proto_err | output | 1 | Mixed write modes across lanes in one column cycle |

## Verification
The bench sweeps every column-strobe state at the row strobe's fall, which separates the two refresh kinds. It then sweeps every lane mask against both write-strobe levels at the column fall and both output-enable levels. This separates read from early write, delayed write from read-modify-write, and shows that an idle lane stays untouched. Directed sequences cover extended output hold across a page gap and a hidden refresh, and column strobes toggling inside a refresh. They also cover page-mode reclassification and staggered lanes that mix write modes, which must raise the error flag, while simultaneous lanes must not.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE  = 3'd0,
        CYC_READ  = 3'd1,
        CYC_EWR   = 3'd2,
        CYC_DWR   = 3'd3,
        CYC_RMW   = 3'd4,
        CYC_RONLY = 3'd5,
        CYC_CBR   = 3'd6
    } cyc_e;

    localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output logic             ras_fall,
    output logic             cas_any,
    output logic             cas_first_fall,
    output logic             we_fall,
    output logic [LANES-1:0] cas_fell
);
    typedef struct packed {
        logic             ras_n;
        logic [LANES-1:0] cas_n;
        logic             we_n;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.ras_n   = ras_n;
        prev_d.cas_n   = cas_n;
        prev_d.we_n    = we_n;
        ras_fall       = prev_q.ras_n & ~ras_n;
        cas_any        = ~(&cas_n);
        cas_first_fall = (&prev_q.cas_n) & cas_any;
        we_fall        = prev_q.we_n & ~we_n;
        cas_fell       = prev_q.cas_n & ~cas_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
    import edo_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic ras_fall,
    input  logic cas_any,
    input  logic cas_first_fall,
    input  logic we_n,
    input  logic we_fall,
    input  logic oe_n,
    output cyc_e cls_nx,
    output cyc_e cls_q
);
    typedef struct packed {
        cyc_e cls;
        logic oe_seen;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ras_n) begin
            st_d.cls     = CYC_IDLE;
            st_d.oe_seen = 1'b0;
        end else if (ras_fall) begin
            st_d.cls     = cas_any ? CYC_CBR : CYC_RONLY;
            st_d.oe_seen = 1'b0;
        end else if (st_q.cls != CYC_CBR) begin
            if (cas_first_fall) begin
                st_d.cls     = we_n ? CYC_READ : CYC_EWR;
                st_d.oe_seen = ~oe_n;
            end else if (st_q.cls == CYC_READ) begin
                if (cas_any && we_fall)
                    st_d.cls = st_q.oe_seen ? CYC_RMW : CYC_DWR;
                else if (cas_any && !oe_n)
                    st_d.oe_seen = 1'b1;
            end
        end
        cls_nx = st_d.cls;
        cls_q  = st_q.cls;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cls: CYC_IDLE, oe_seen: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
    import edo_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic cas_fell,
    input  logic cas_any,
    input  logic we_n,
    input  logic oe_n,
    input  cyc_e cls_nx,
    output logic wr_q,
    output logic drv_q,
    output logic seen_nx,
    output logic early_nx
);
    typedef struct packed {
        logic wr;
        logic drv;
        logic seen;
        logic early;
    } lane_t;

    lane_t ln_d, ln_q;
    logic  is_write, drv_set, drv_hold;

    always_comb begin
        ln_d     = ln_q;
        is_write = (cls_nx == CYC_EWR) || (cls_nx == CYC_DWR) || (cls_nx == CYC_RMW);
        ln_d.wr  = ~ras_n & ~cas_n & ~we_n & is_write;
        drv_set  = ~ras_n & ~cas_n & ~oe_n & we_n & (cls_nx == CYC_READ);
        drv_hold = ln_q.drv & (~ras_n | ~cas_n) & ~oe_n & we_n;
        ln_d.drv = drv_set | drv_hold;
        if (ras_n || !cas_any) begin
            ln_d.seen  = 1'b0;
            ln_d.early = 1'b0;
        end else if (cas_fell) begin
            ln_d.seen  = 1'b1;
            ln_d.early = ~we_n;
        end
        wr_q     = ln_q.wr;
        drv_q    = ln_q.drv;
        seen_nx  = ln_d.seen;
        early_nx = ln_d.early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end
endmodule

// File: rtl/edo_mode_decoder.sv
module edo_mode_decoder
    import edo_dec_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [MODE_W-1:0] mode,
    output logic [LANES-1:0]  wr_en,
    output logic [LANES-1:0]  drv_en,
    output logic              proto_err
);
    logic             ras_fall, cas_any, cas_first_fall, we_fall;
    logic [LANES-1:0] cas_fell, seen_nx, early_nx;
    cyc_e             cls_nx, cls_q;
    logic             err_d, err_q;

    edo_strobe_edges #(.LANES(LANES)) u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .cas_any(cas_any), .cas_first_fall(cas_first_fall),
        .we_fall(we_fall), .cas_fell(cas_fell)
    );

    edo_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ras_fall(ras_fall),
        .cas_any(cas_any), .cas_first_fall(cas_first_fall), .we_n(we_n),
        .we_fall(we_fall), .oe_n(oe_n), .cls_nx(cls_nx), .cls_q(cls_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctrl u_lane (
            .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n[g]),
            .cas_fell(cas_fell[g]), .cas_any(cas_any), .we_n(we_n), .oe_n(oe_n),
            .cls_nx(cls_nx), .wr_q(wr_en[g]), .drv_q(drv_en[g]),
            .seen_nx(seen_nx[g]), .early_nx(early_nx[g])
        );
    end

    // Mixed write kinds among lanes of one column cycle latch an error.
    always_comb begin
        err_d = err_q;
        if (ras_n)
            err_d = 1'b0;
        else if ((|(seen_nx & early_nx)) && (|(seen_nx & ~early_nx)))
            err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign mode      = cls_q;
    assign proto_err = err_q;
endmodule

// File: rtl/edo_mode_decoder_chk.sv
module edo_mode_decoder_chk
    import edo_dec_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic [LANES-1:0]  cas_n,
    input logic              we_n,
    input logic [MODE_W-1:0] mode,
    input logic [LANES-1:0]  wr_en,
    input logic [LANES-1:0]  drv_en,
    input logic              proto_err
);
    a_r1_idle_row_high: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |=> mode == CYC_IDLE);

    a_r2_cbr_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (cas_n != '1)) |=> mode == CYC_CBR);

    a_r3_row_only_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (cas_n == '1)) |=> mode == CYC_RONLY);

    a_r6_write_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        we_n |=> wr_en == '0);

    a_r7_early_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CYC_EWR) |-> drv_en == '0);

    a_r7_we_low_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> drv_en == '0);

    a_r10_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |=> !proto_err);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        a_r9_idle_lane_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            cas_n[g] |=> !wr_en[g]);
    end
endmodule

bind edo_mode_decoder edo_mode_decoder_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .mode(mode), .wr_en(wr_en), .drv_en(drv_en), .proto_err(proto_err)
);

// File: tb/edo_mode_decoder_bench.sv
module edo_mode_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic [1:0] cas_n = 2'b11;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [2:0] mode;
    logic [1:0] wr_en, drv_en;
    logic       proto_err;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    edo_mode_decoder #(.LANES(2)) u_edo_mode_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .mode(mode), .wr_en(wr_en), .drv_en(drv_en), .proto_err(proto_err)
    );

    // Drive at a falling edge, return at the next falling edge (one rising edge between).
    task automatic step(input logic r, input logic [1:0] c, input logic w, input logic o);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] em, input logic [1:0] ew,
                       input logic [1:0] ed, input logic ee);
        n_chk++;
        if (mode !== em || wr_en !== ew || drv_en !== ed || proto_err !== ee) begin
            n_bad++;
            $display("FAIL %s: mode=%0d wr=%b drv=%b err=%b expected mode=%0d wr=%b drv=%b err=%b",
                     tag, mode, wr_en, drv_en, proto_err, em, ew, ed, ee);
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", 3'd0, 2'b00, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Refresh kind from column strobes at the row fall (R2, R3)
        for (int c = 0; c < 4; c++) begin
            step(1'b1, 2'b11, 1'b1, 1'b1);
            chk("R1 idle", 3'd0, 2'b00, 2'b00, 1'b0);
            step(1'b0, 2'(c), 1'b1, 1'b1);
            chk((c == 3) ? "R3 row-only" : "R2 cbr", (c == 3) ? 3'd5 : 3'd6, 2'b00, 2'b00, 1'b0);
        end

        // Lane masks x write strobe x output enable (R4 R5 R6 R7 R9)
        for (int m = 1; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [1:0] msk;
                    logic [2:0] em;
                    msk = 2'(m);
                    step(1'b1, 2'b11, 1'b1, 1'b1);
                    step(1'b0, 2'b11, 1'b1, 1'b1);
                    chk("R3 held before column", 3'd5, 2'b00, 2'b00, 1'b0);
                    step(1'b0, ~msk, 1'(w), 1'(o));
                    em = (w == 1) ? 3'd1 : 3'd2;
                    chk("R4 R6 R7 R9 column fall", em,
                        (w == 0) ? msk : 2'b00, (w == 1 && o == 0) ? msk : 2'b00, 1'b0);
                    if (w == 1) begin
                        step(1'b0, ~msk, 1'b0, 1'(o));
                        em = (o == 1) ? 3'd3 : 3'd4;
                        chk("R5 R6 late write", em, msk, 2'b00, 1'b0);
                    end
                    step(1'b0, 2'b11, 1'b1, 1'b1);
                    chk("R6 column high", em, 2'b00, 2'b00, 1'b0);
                end
            end
        end

        // Extended output hold across a page gap (R8)
        step(1'b1, 2'b11, 1'b1, 1'b1);
        step(1'b0, 2'b11, 1'b1, 1'b0);
        step(1'b0, 2'b10, 1'b1, 1'b0);
        chk("R7 lower read", 3'd1, 2'b00, 2'b01, 1'b0);
        step(1'b0, 2'b11, 1'b1, 1'b0);
        chk("R8 page gap hold", 3'd1, 2'b00, 2'b01, 1'b0);
        step(1'b1, 2'b11, 1'b1, 1'b0);
        chk("R8 both high off", 3'd0, 2'b00, 2'b00, 1'b0);

        // Hidden refresh keeps lower lane driving (R8, R2)
        step(1'b0, 2'b11, 1'b1, 1'b0);
        step(1'b0, 2'b10, 1'b1, 1'b0);
        step(1'b1, 2'b10, 1'b1, 1'b0);
        chk("R8 row high column low", 3'd0, 2'b00, 2'b01, 1'b0);
        step(1'b0, 2'b10, 1'b1, 1'b0);
        chk("R2 R8 hidden refresh", 3'd6, 2'b00, 2'b01, 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b1);
        chk("R2 strobes ignored in refresh", 3'd6, 2'b00, 2'b00, 1'b0);
        step(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R1 after refresh", 3'd0, 2'b00, 2'b00, 1'b0);

        // Staggered lanes with mixed write kinds (R10)
        step(1'b0, 2'b11, 1'b1, 1'b1);
        step(1'b0, 2'b10, 1'b1, 1'b1);
        chk("R4 lower read", 3'd1, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b1);
        chk("R10 mixed modes", 3'd3, 2'b11, 2'b00, 1'b1);
        step(1'b0, 2'b11, 1'b1, 1'b1);
        chk("R10 sticky", 3'd3, 2'b00, 2'b00, 1'b1);
        step(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R10 cleared", 3'd0, 2'b00, 2'b00, 1'b0);

        // Page reclassification (R4)
        step(1'b0, 2'b11, 1'b1, 1'b1);
        step(1'b0, 2'b00, 1'b1, 1'b1);
        chk("R4 page read", 3'd1, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b1, 1'b1);
        step(1'b0, 2'b01, 1'b0, 1'b1);
        chk("R4 R9 page early write upper", 3'd2, 2'b10, 2'b00, 1'b0);
        step(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R1 end", 3'd0, 2'b00, 2'b00, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule